// File: doc/BRIEF.md
# Load-Use Stall Unit

This block guards an in-order pipeline against the one data dependency that forwarding cannot cover. A load in the execute stage does not have its data until the end of the memory stage. An instruction in the decode stage that reads the load's destination register therefore has to wait one cycle. The unit compares the destination number of an execute-stage load with both source register numbers of the decode-stage instruction.

On a match, the unit freezes the program counter and the fetch/decode register, so the dependent instruction is decoded again and the following one is fetched again. In the same cycle it tells the decode/execute register to capture all-zero control values, which turns that slot into a no-operation bubble. On the next cycle the bubble sits in execute with its read-memory flag clear, so the stall ends without further logic. The load result can then be forwarded from the memory/writeback register.

The outputs are combinational from the current contents of the pipeline registers. The unit holds no state of its own.

Top module: `loaduse_stall_unit`

## Requirements
- R1: When `exMemRead` is 1 and `exRt` equals `idRs`, the unit stalls: `pcWrEn` = 0, `ifIdWrEn` = 0 and `idExCtrlZero` = 1.
- R2: When `exMemRead` is 1 and `exRt` equals `idRt`, the unit stalls in the same way as R1.
- R3: When `exMemRead` is 1 and `exRt` equals both `idRs` and `idRt`, the result is the same single stall (`pcWrEn` = 0, `ifIdWrEn` = 0, `idExCtrlZero` = 1).
- R4: When `exMemRead` is 0, the unit does not stall, whatever the register numbers: `pcWrEn` = 1, `ifIdWrEn` = 1, `idExCtrlZero` = 0.
- R5: When `exMemRead` is 1 but `exRt` matches neither source number, the unit does not stall. This holds even when the numbers differ in a single bit.
- R6: The outputs follow the inputs within the same cycle, with no clock edge in between.
- R7: `pcWrEn` and `ifIdWrEn` are always equal to each other, and `idExCtrlZero` is always their complement.
- R8: In a pipeline that applies the three strobes, each load directly followed by a dependent instruction costs exactly one bubble cycle. Two stall cycles never come back to back. Every instruction enters the decode/execute register exactly once, in program order.
- R9: Register number 0 is compared like any other: a load whose destination is 0 stalls a following reader of register 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| exMemRead | input | 1 | Read-memory control flag of the instruction in the decode/execute register |
| exRt | input | REG_IDX_W | Destination register number of that (load) instruction |
| idRs | input | REG_IDX_W | First source register number of the instruction in the fetch/decode register |
| idRt | input | REG_IDX_W | Second source register number of the instruction in the fetch/decode register |
| pcWrEn | output | 1 | Program counter update enable; 0 holds the counter |
| ifIdWrEn | output | 1 | Fetch/decode register update enable; 0 holds it |
| idExCtrlZero | output | 1 | 1 forces the control fields entering the decode/execute register to zero |

## Verification
Two functions can fall in the same cycle:
- **Both sources match.** The first-source and second-source comparisons can hit together when both operands name the loaded register. Vectors with all three numbers equal must still yield one plain stall (R3).
- **A new load is itself the dependent.** A load can sit in decode as the dependent of the load ahead of it, so it is being held back at the same moment it becomes the next load to guard against. A small pipeline model in the bench runs a program containing such a back-to-back dependent load pair. A scoreboard expects every instruction to reach the execute slot once and in order. The bench also checks that exactly four isolated bubble cycles appear.

// File: rtl/luh_pkg.sv
package luh_pkg;

  // Default width of a register number.
  localparam int DEF_REG_IDX_W = 5;

  // Strobes from the hazard control to the output stage.
  typedef struct packed {
    logic pcHold;     // freeze the program counter
    logic ifIdHold;   // freeze the fetch/decode register
    logic bubbleIns;  // zero the control fields entering decode/execute
  } stallStrobe_t;

endpackage

// File: rtl/luh_match_dp.sv
// Compares the execute-stage destination with every decode-stage source.
module luh_match_dp #(
  parameter int REG_IDX_W = luh_pkg::DEF_REG_IDX_W,
  parameter int NUM_SRC   = 2
) (
  input  logic [REG_IDX_W-1:0]              exRt,
  input  logic [NUM_SRC-1:0][REG_IDX_W-1:0] srcIdx,
  output logic [NUM_SRC-1:0]                srcHit
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign srcHit[g] = (srcIdx[g] == exRt);
  end

endmodule

// File: rtl/luh_ctrl.sv
// Turns source hits plus the load flag into the stall strobes.
module luh_ctrl #(
  parameter int NUM_SRC = 2
) (
  input  logic                 exMemRead,
  input  logic [NUM_SRC-1:0]   srcHit,
  output luh_pkg::stallStrobe_t strobe
);

  logic loadUse;

  always_comb begin
    loadUse          = exMemRead && (|srcHit);
    strobe.pcHold    = loadUse;
    strobe.ifIdHold  = loadUse;
    strobe.bubbleIns = loadUse;
  end

endmodule

// File: rtl/loaduse_stall_unit.sv
module loaduse_stall_unit #(
  parameter int REG_IDX_W = luh_pkg::DEF_REG_IDX_W
) (
  input  logic                 exMemRead,
  input  logic [REG_IDX_W-1:0] exRt,
  input  logic [REG_IDX_W-1:0] idRs,
  input  logic [REG_IDX_W-1:0] idRt,
  output logic                 pcWrEn,
  output logic                 ifIdWrEn,
  output logic                 idExCtrlZero
);

  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_IDX_W-1:0] srcIdx;
  logic [NUM_SRC-1:0]                srcHit;
  luh_pkg::stallStrobe_t             strobe;

  assign srcIdx[0] = idRs;
  assign srcIdx[1] = idRt;

  luh_match_dp #(
    .REG_IDX_W(REG_IDX_W),
    .NUM_SRC  (NUM_SRC)
  ) u_dp (
    .exRt  (exRt),
    .srcIdx(srcIdx),
    .srcHit(srcHit)
  );

  luh_ctrl #(
    .NUM_SRC(NUM_SRC)
  ) u_ctrl (
    .exMemRead(exMemRead),
    .srcHit   (srcHit),
    .strobe   (strobe)
  );

  assign pcWrEn       = !strobe.pcHold;
  assign ifIdWrEn     = !strobe.ifIdHold;
  assign idExCtrlZero = strobe.bubbleIns;

endmodule

// File: rtl/luh_checker.sv
module luh_checker #(
  parameter int REG_IDX_W = luh_pkg::DEF_REG_IDX_W
) (
  input logic                 exMemRead,
  input logic [REG_IDX_W-1:0] exRt,
  input logic [REG_IDX_W-1:0] idRs,
  input logic [REG_IDX_W-1:0] idRt,
  input logic                 pcWrEn,
  input logic                 ifIdWrEn,
  input logic                 idExCtrlZero
);

  always_comb begin
    AST_RS_LOAD_STALLS: assert (!(exMemRead && exRt == idRs) || (!pcWrEn && idExCtrlZero))
      else $error("first-source load-use did not stall"); // R1
    AST_RT_LOAD_STALLS: assert (!(exMemRead && exRt == idRt) || (!ifIdWrEn && idExCtrlZero))
      else $error("second-source load-use did not stall"); // R2
    AST_NO_LOAD_NO_STALL: assert (exMemRead || (pcWrEn && ifIdWrEn && !idExCtrlZero))
      else $error("stall without a load in execute"); // R4
    AST_NO_MATCH_NO_STALL: assert (!(exRt != idRs && exRt != idRt) || !idExCtrlZero)
      else $error("stall without a register match"); // R5
    AST_STROBES_AGREE: assert ((pcWrEn == ifIdWrEn) && (idExCtrlZero == !pcWrEn))
      else $error("stall strobes disagree"); // R7
  end

endmodule

bind loaduse_stall_unit luh_checker #(.REG_IDX_W(REG_IDX_W)) u_luh_checker (.*);

// File: tb/loaduse_stall_unit_bench.sv
module loaduse_stall_unit_bench;

  localparam int W = 5;
  localparam int N = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic rst_n = 1'b0;
  logic pipeMode = 1'b1;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  // direct-drive inputs
  logic         drvMemRead = 1'b0;
  logic [W-1:0] drvExRt = '0, drvRs = '0, drvRt = '0;

  // pipeline model state
  int           pc;
  int           ifIdId, idExId;
  logic         ifIdLoad;
  logic [W-1:0] ifIdRs, ifIdRt;
  logic         idExMemRead;
  logic [W-1:0] idExRt;

  logic         progLoad [N];
  logic [W-1:0] progRs [N];
  logic [W-1:0] progRt [N];

  logic         exMemRead;
  logic [W-1:0] exRt, idRs, idRt;
  logic         pcWrEn, ifIdWrEn, idExCtrlZero;

  assign exMemRead = pipeMode ? idExMemRead : drvMemRead;
  assign exRt      = pipeMode ? idExRt      : drvExRt;
  assign idRs      = pipeMode ? ifIdRs      : drvRs;
  assign idRt      = pipeMode ? ifIdRt      : drvRt;

  loaduse_stall_unit #(.REG_IDX_W(W)) u_loaduse_stall_unit (
    .exMemRead(exMemRead), .exRt(exRt), .idRs(idRs), .idRt(idRt),
    .pcWrEn(pcWrEn), .ifIdWrEn(ifIdWrEn), .idExCtrlZero(idExCtrlZero)
  );

  // scoreboard queues
  logic [2:0] expQ [$];
  string      tagQ [$];
  int         orderQ [$];
  int         stallCnt = 0;
  logic       prevStall = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: applies a vector after a rising edge, queues the expected strobes
  task automatic applyVec(input logic mr, input logic [W-1:0] rt0,
                          input logic [W-1:0] s0, input logic [W-1:0] s1,
                          input bit stall, input string tag);
    @(posedge clk);
    #1;
    drvMemRead = mr; drvExRt = rt0; drvRs = s0; drvRt = s1;
    expQ.push_back(stall ? 3'b001 : 3'b110);  // {pcWrEn, ifIdWrEn, idExCtrlZero}
    tagQ.push_back(tag);
  endtask

  // monitor for direct vectors
  always @(negedge clk) begin
    if (!pipeMode && expQ.size() > 0) begin
      logic [2:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check({pcWrEn, ifIdWrEn, idExCtrlZero} == e, t, "strobes",
            int'({pcWrEn, ifIdWrEn, idExCtrlZero}), int'(e));
    end
  end

  // pipeline model: applies the design's strobes
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= 0; ifIdId <= -1; ifIdLoad <= 1'b0; ifIdRs <= '0; ifIdRt <= '0;
      idExId <= -1; idExMemRead <= 1'b0; idExRt <= '0;
    end else if (pipeMode) begin
      if (pcWrEn) pc <= pc + 1;
      if (ifIdWrEn) begin
        if (pc < N) begin
          ifIdId <= pc; ifIdLoad <= progLoad[pc];
          ifIdRs <= progRs[pc]; ifIdRt <= progRt[pc];
        end else begin
          ifIdId <= -1; ifIdLoad <= 1'b0; ifIdRs <= '0; ifIdRt <= '0;
        end
      end
      if (idExCtrlZero) begin
        idExMemRead <= 1'b0; idExId <= -1;
      end else begin
        idExMemRead <= ifIdLoad; idExId <= ifIdId; idExRt <= ifIdRt;
      end
    end
  end

  // monitor for the pipeline run: order of entries and bubble count (R8)
  always @(negedge clk) begin
    if (pipeMode && rst_n) begin
      if (idExId >= 0) begin
        int e;
        e = (orderQ.size() > 0) ? orderQ.pop_front() : -99;
        check(idExId == e, "R8", "entry order", idExId, e);
      end
      if (idExCtrlZero) begin
        stallCnt++;
        if (prevStall) check(1'b0, "R8", "back-to-back stall", 1, 0);
      end
      prevStall = idExCtrlZero;
    end
  end

  initial begin
    // program: loads write their rt field
    progLoad[0] = 1; progRs[0] = 1; progRt[0] = 3;
    progLoad[1] = 0; progRs[1] = 3; progRt[1] = 2;  // uses 3: stall
    progLoad[2] = 1; progRs[2] = 1; progRt[2] = 5;
    progLoad[3] = 0; progRs[3] = 6; progRt[3] = 5;  // uses 5: stall
    progLoad[4] = 1; progRs[4] = 1; progRt[4] = 7;
    progLoad[5] = 0; progRs[5] = 8; progRt[5] = 9;
    progLoad[6] = 0; progRs[6] = 7; progRt[6] = 7;  // two apart: no stall
    progLoad[7] = 1; progRs[7] = 9; progRt[7] = 2;
    progLoad[8] = 1; progRs[8] = 2; progRt[8] = 4;  // load uses load: stall
    progLoad[9] = 0; progRs[9] = 4; progRt[9] = 4;  // uses 4: stall

    // reset state: empty pipeline, no stall
    repeat (2) @(posedge clk);
    #5;
    check({pcWrEn, ifIdWrEn, idExCtrlZero} == 3'b110, "R4", "reset state",
          int'({pcWrEn, ifIdWrEn, idExCtrlZero}), 6);

    // direct vectors
    pipeMode = 1'b0;
    applyVec(1'b0, 5'd3,  5'd3,  5'd3,  0, "R4");
    applyVec(1'b0, 5'd0,  5'd0,  5'd0,  0, "R4");
    applyVec(1'b1, 5'd7,  5'd7,  5'd2,  1, "R1");
    applyVec(1'b1, 5'd31, 5'd31, 5'd0,  1, "R1");
    applyVec(1'b1, 5'd9,  5'd1,  5'd9,  1, "R2");
    applyVec(1'b1, 5'd4,  5'd4,  5'd4,  1, "R3");
    applyVec(1'b1, 5'd5,  5'd6,  5'd4,  0, "R5");
    applyVec(1'b1, 5'd31, 5'd30, 5'd15, 0, "R5");
    applyVec(1'b1, 5'd0,  5'd0,  5'd1,  1, "R9");
    applyVec(1'b1, 5'd0,  5'd8,  5'd0,  1, "R9");
    for (int b = 0; b < W; b++) begin
      applyVec(1'b1, 5'(1 << b), 5'd0, 5'(~(1 << b)), 0, "R5");
    end
    repeat (2) @(posedge clk);

    // combinational response without any clock edge (R6, R7)
    @(posedge clk);
    #1;
    drvMemRead = 1'b1; drvExRt = 5'd12; drvRs = 5'd11; drvRt = 5'd13;
    #2;
    check(idExCtrlZero == 1'b0, "R6", "no-match value", int'(idExCtrlZero), 0);
    drvRt = 5'd12;
    #2;
    check({pcWrEn, ifIdWrEn, idExCtrlZero} == 3'b001, "R6", "same-cycle stall",
          int'({pcWrEn, ifIdWrEn, idExCtrlZero}), 1);
    drvMemRead = 1'b0;
    #2;
    check({pcWrEn, ifIdWrEn, idExCtrlZero} == 3'b110, "R7", "same-cycle release",
          int'({pcWrEn, ifIdWrEn, idExCtrlZero}), 6);

    // pipeline run
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    pipeMode = 1'b1;
    for (int i = 0; i < N; i++) orderQ.push_back(i);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (30) @(posedge clk);
    #5;
    check(stallCnt == 4, "R8", "bubble count", stallCnt, 4);
    check(orderQ.size() == 0, "R8", "entries left", orderQ.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule